// File: doc/BRIEF.md
# Network Adapter Interrupt Cause, Mask and Throttle Controller

This block holds the interrupt cause, mask and auto-mask registers of a network adapter and drives one level-sensitive interrupt line to the host. Other parts of the adapter raise single-cycle event pulses on a cause vector. Those parts include the receive delay timers, the DMA engines and the packet datapath, and none of them is part of this block. A second vector carries urgent posts, which must reach the host without waiting for the pacing timer.

The host reaches the block through a simple 32-bit register port. A read of the cause register can clear it, depending on the line state and the mask. A write to it clears individual causes, one bit per cause. A host-selected subset of the mask can drop out automatically when an asserted cause register is read. A throttle interval spaces assertions in units of 128 device cycles, which is 256 ns at 500 MHz. An interval of zero turns pacing off.

Top module: `nic_irq_ctrl`

## Requirements
- R1: After reset the line is low and every register reads zero. A read of the cause register (address 0) returns the line state in bit 31 and the pending causes in bits 30:0.
- R2: A cause read clears bits 30:0 in the same cycle when either the line is asserted or the mask is zero. Otherwise the read leaves the causes unchanged.
- R3: Bit 0 of the control register (address 4) enables auto-masking. While it is set, a cause read taken while the line is asserted clears every mask bit that is set in the auto-mask register (address 2). A cause read taken with the line low leaves the mask unchanged.
- R4: A write to the cause register clears each cause bit in 30:0 whose written bit is 1. Causes written as 0 keep their value.
- R5: Posting a cause that is already pending has no effect. It neither restarts a running throttle count nor counts as an urgent post.
- R6: With an interval of zero, the line rises on the clock edge at which the cause AND mask becomes nonzero.
- R7: With a nonzero interval N (address 3, bits 15:0), the throttle count starts at the edge where cause AND mask first becomes nonzero while the line is low. The line rises N*128 edges later. Causes that arrive while the count runs do not restart it.
- R8: An urgent post of an unmasked cause that is not already pending cancels any running count and raises the line at that same edge.
- R9: When cause AND mask becomes zero, the line drops and any running count is cancelled. A count that starts later begins again from its full value.
- R10: A cause pulse that arrives in the same cycle as a clearing read or write survives the clear.
- R11: The mask (address 1), auto-mask (address 2), interval and control registers read back the value last written. Only the 31 mask bits, 16 interval bits and one control bit are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 31 | Cause pulses posted under throttle pacing |
| urg_i | input | 31 | Cause pulses posted as urgent |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the strobe |
| irq_o | output | 1 | Level interrupt line to the host |

## Verification
The bench checks the read-to-clear conditions from both sides. A read with the line low and the mask nonzero must keep the causes, and a design that always clears would lose them. A read with a zero mask must clear them, and a design that tests only the line would keep them. It times the throttle count to the exact edge, both for a second cause arriving mid-count and for a mask cleared and restored mid-count. A design that restarts the count, or fails to cancel it, fires early or late. It checks three more corner cases. An urgent post of a cause that is already pending must not raise the line. Auto-masking must apply only when the line is asserted. A pulse arriving during a clearing read must survive.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
    localparam int CAUSE_W = 31;
    localparam int DATA_W  = 32;

    typedef enum logic [2:0] {
        RA_CAUSE = 3'd0,
        RA_MASK  = 3'd1,
        RA_AMASK = 3'd2,
        RA_ITVL  = 3'd3,
        RA_CTRL  = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/nic_irq_cause.sv
module nic_irq_cause
    import nic_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_cause_i,
    input  logic               wr_cause_i,
    input  logic               wr_mask_i,
    input  logic               wr_amask_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [CAUSE_W-1:0] evt_i,
    input  logic [CAUSE_W-1:0] urg_i,
    input  logic               ame_i,
    input  logic               line_i,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [CAUSE_W-1:0] mask_o,
    output logic [CAUSE_W-1:0] amask_o,
    output logic               pend_next_o,
    output logic               urg_hit_o
);
    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic [CAUSE_W-1:0] mask;
        logic [CAUSE_W-1:0] amask;
    } cst_t;

    cst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_cause_i && (line_i || st_q.mask == '0))
            st_d.cause = '0;
        if (rd_cause_i && ame_i && line_i)
            st_d.mask = st_q.mask & ~st_q.amask;
        if (wr_cause_i)
            st_d.cause = st_d.cause & ~wdata_i[CAUSE_W-1:0];
        if (wr_mask_i)
            st_d.mask = wdata_i[CAUSE_W-1:0];
        if (wr_amask_i)
            st_d.amask = wdata_i[CAUSE_W-1:0];
        urg_hit_o   = |(urg_i & ~st_d.cause & st_d.mask);
        st_d.cause  = st_d.cause | evt_i | urg_i;
        pend_next_o = |(st_d.cause & st_d.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;
    assign amask_o = st_q.amask;
endmodule

// File: rtl/nic_irq_throttle.sv
module nic_irq_throttle #(
    parameter int ITV_W    = 16,
    parameter int UNIT_CYC = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_i,
    input  logic             urg_hit_i,
    input  logic [ITV_W-1:0] itv_i,
    output logic             line_o
);
    localparam int CNT_W = ITV_W + $clog2(UNIT_CYC) + 1;

    typedef struct packed {
        logic             line;
        logic [CNT_W-1:0] cnt;
    } tst_t;

    tst_t st_d, st_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val = CNT_W'(itv_i) * CNT_W'(UNIT_CYC);
        st_d = st_q;
        if (!pend_i) begin
            st_d.line = 1'b0;
            st_d.cnt  = '0;
        end else if (urg_hit_i) begin
            st_d.line = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.line) begin
            st_d.cnt  = '0;
        end else if (itv_i == '0) begin
            st_d.line = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.cnt == '0) begin
            st_d.cnt  = load_val;
        end else if (st_q.cnt == CNT_W'(1)) begin
            st_d.cnt  = '0;
            st_d.line = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_o = st_q.line;
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
    import nic_irq_pkg::*;
#(
    parameter int ITV_W    = 16,
    parameter int UNIT_CYC = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] evt_i,
    input  logic [CAUSE_W-1:0] urg_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic [2:0]         reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [ITV_W-1:0] itv;
        logic             ame;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [CAUSE_W-1:0] cause_q, mask_q, amask_q;
    logic pend_next, urg_hit, line_q;
    logic sel_cause, sel_mask, sel_amask, sel_itv, sel_ctrl;

    always_comb begin
        sel_cause = reg_addr_i == RA_CAUSE;
        sel_mask  = reg_addr_i == RA_MASK;
        sel_amask = reg_addr_i == RA_AMASK;
        sel_itv   = reg_addr_i == RA_ITVL;
        sel_ctrl  = reg_addr_i == RA_CTRL;
        cfg_d = cfg_q;
        if (reg_wr_i && sel_itv)  cfg_d.itv = reg_wdata_i[ITV_W-1:0];
        if (reg_wr_i && sel_ctrl) cfg_d.ame = reg_wdata_i[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    nic_irq_cause u_cause (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_cause_i  (reg_rd_i && sel_cause),
        .wr_cause_i  (reg_wr_i && sel_cause),
        .wr_mask_i   (reg_wr_i && sel_mask),
        .wr_amask_i  (reg_wr_i && sel_amask),
        .wdata_i     (reg_wdata_i),
        .evt_i       (evt_i),
        .urg_i       (urg_i),
        .ame_i       (cfg_q.ame),
        .line_i      (line_q),
        .cause_o     (cause_q),
        .mask_o      (mask_q),
        .amask_o     (amask_q),
        .pend_next_o (pend_next),
        .urg_hit_o   (urg_hit)
    );

    nic_irq_throttle #(.ITV_W(ITV_W), .UNIT_CYC(UNIT_CYC)) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend_next),
        .urg_hit_i (urg_hit),
        .itv_i     (cfg_q.itv),
        .line_o    (line_q)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (1'b1)
            sel_cause: reg_rdata_o = {line_q, cause_q};
            sel_mask:  reg_rdata_o = {1'b0, mask_q};
            sel_amask: reg_rdata_o = {1'b0, amask_q};
            sel_itv:   reg_rdata_o = DATA_W'(cfg_q.itv);
            sel_ctrl:  reg_rdata_o = DATA_W'(cfg_q.ame);
            default:   reg_rdata_o = '0;
        endcase
    end

    assign irq_o = line_q;
endmodule

// File: rtl/nic_irq_ctrl_chk.sv
module nic_irq_ctrl_chk #(
    parameter int CW    = 31,
    parameter int ITV_W = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] evt_i,
    input logic [CW-1:0] urg_i,
    input logic          reg_wr_i,
    input logic          reg_rd_i,
    input logic [2:0]    reg_addr_i,
    input logic [31:0]   reg_wdata_i,
    input logic          irq_o,
    input logic [CW-1:0] cause_q,
    input logic [CW-1:0] mask_q,
    input logic [ITV_W-1:0] itv_q
);
    logic cause_acc;
    assign cause_acc = (reg_wr_i || reg_rd_i) && reg_addr_i == 3'd0;

    // R9
    line_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> |(cause_q & mask_q));

    // R4
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 3'd0) |=>
        ((cause_q & $past(reg_wdata_i[CW-1:0])) ==
         (($past(evt_i) | $past(urg_i)) & $past(reg_wdata_i[CW-1:0]))));

    // R5
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_acc |=> (($past(cause_q) & ~cause_q) == '0));

    // R6
    zero_itv_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (itv_q == '0 && |(cause_q & mask_q) && !reg_wr_i && !reg_rd_i) |=> irq_o);

    // R8
    urgent_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(urg_i & ~cause_q & mask_q) && !reg_wr_i && !reg_rd_i) |=> irq_o);

    // R10
    evt_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_acc |=> ((cause_q & $past(evt_i)) == $past(evt_i)));
endmodule

bind nic_irq_ctrl nic_irq_ctrl_chk #(.CW(nic_irq_pkg::CAUSE_W), .ITV_W(ITV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .urg_i       (urg_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_o       (irq_o),
    .cause_q     (cause_q),
    .mask_q      (mask_q),
    .itv_q       (cfg_q.itv)
);

// File: tb/sim_nic_irq_ctrl.sv
module sim_nic_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [30:0] evt_i = '0;
    logic [30:0] urg_i = '0;
    logic        reg_wr_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [2:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nic_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .urg_i(urg_i),
        .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    localparam logic [1:0] K_NOP = 2'd0, K_WR = 2'd1, K_RD = 2'd2;
    localparam logic [2:0] A_C = 3'd0, A_M = 3'd1, A_A = 3'd2, A_I = 3'd3, A_K = 3'd4;

    typedef struct packed {
        logic [1:0]  kind;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [30:0] evt;
        logic [31:0] exp_rd;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{K_WR,  A_M, 32'hF,   31'h0,   32'h0,        1'b0}, // R11
        '{K_NOP, A_C, 32'h0,   31'h10,  32'h0,        1'b0}, // masked cause, R6
        '{K_RD,  A_M, 32'h0,   31'h0,   32'hF,        1'b0}, // R11
        '{K_NOP, A_C, 32'h0,   31'h1,   32'h0,        1'b1}, // R6
        '{K_RD,  A_C, 32'h0,   31'h0,   32'h8000_0011,1'b0}, // R2, R1, R9
        '{K_RD,  A_C, 32'h0,   31'h0,   32'h0,        1'b0}, // R2
        '{K_WR,  A_M, 32'h0,   31'h0,   32'h0,        1'b0},
        '{K_NOP, A_C, 32'h0,   31'h6,   32'h0,        1'b0}, // R9
        '{K_RD,  A_C, 32'h0,   31'h0,   32'h6,        1'b0}, // R2 zero mask
        '{K_RD,  A_C, 32'h0,   31'h0,   32'h0,        1'b0}, // R2
        '{K_WR,  A_M, 32'hFF,  31'h0,   32'h0,        1'b0},
        '{K_NOP, A_C, 32'h0,   31'h30,  32'h0,        1'b1}, // R6
        '{K_WR,  A_C, 32'h10,  31'h0,   32'h0,        1'b1}, // R4
        '{K_WR,  A_C, 32'h20,  31'h0,   32'h0,        1'b0}, // R4, R9
        '{K_RD,  A_C, 32'h0,   31'h0,   32'h0,        1'b0}, // R4
        '{K_NOP, A_C, 32'h0,   31'h100, 32'h0,        1'b0},
        '{K_RD,  A_C, 32'h0,   31'h0,   32'h100,      1'b0}, // R2 kept
        '{K_RD,  A_C, 32'h0,   31'h0,   32'h100,      1'b0}, // R2 kept
        '{K_WR,  A_C, 32'h100, 31'h0,   32'h0,        1'b0}, // R4
        '{K_RD,  A_C, 32'h0,   31'h0,   32'h0,        1'b0}  // R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] kind, input logic [2:0] addr, input logic [31:0] data,
                      input logic [30:0] evt, input logic [30:0] urg, output logic [31:0] rd);
        @(negedge clk);
        reg_wr_i = (kind == K_WR);
        reg_rd_i = (kind == K_RD);
        reg_addr_i = addr;
        reg_wdata_i = data;
        evt_i = evt;
        urg_i = urg;
        #1 rd = reg_rdata_o;
        @(posedge clk);
        #1;
        reg_wr_i = 1'b0;
        reg_rd_i = 1'b0;
        evt_i = '0;
        urg_i = '0;
    endtask

    task automatic clean();
        logic [31:0] d;
        op(K_WR, A_I, 32'h0, '0, '0, d);
        op(K_WR, A_C, 32'h7FFF_FFFF, '0, '0, d);
        op(K_WR, A_M, 32'hF, '0, '0, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 irq after reset", {31'h0, irq_o}, 32'h0);
        for (int a = 0; a < 5; a++) begin
            op(K_RD, 3'(a), 32'h0, '0, '0, d);
            check("R1 register reset value", d, 32'h0);
        end

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].kind, VECS[i].addr, VECS[i].data, VECS[i].evt, '0, d);
            if (VECS[i].kind == K_RD)
                check($sformatf("R2/R4/R11 vector %0d rdata", i), d, VECS[i].exp_rd);
            check($sformatf("R6/R9 vector %0d irq", i), {31'h0, irq_o}, {31'h0, VECS[i].exp_irq});
        end

        // R3 auto-mask
        op(K_WR, A_K, 32'h1, '0, '0, d);
        op(K_WR, A_A, 32'h3, '0, '0, d);
        op(K_WR, A_M, 32'hF, '0, '0, d);
        op(K_NOP, A_C, 32'h0, 31'h1, '0, d);
        check("R3 irq before read", {31'h0, irq_o}, 32'h1);
        op(K_RD, A_C, 32'h0, '0, '0, d);
        check("R3 cause read", d, 32'h8000_0001);
        op(K_RD, A_M, 32'h0, '0, '0, d);
        check("R3 mask after auto-mask", d, 32'hC);
        op(K_NOP, A_C, 32'h0, 31'h100, '0, d);
        op(K_RD, A_C, 32'h0, '0, '0, d);
        op(K_RD, A_M, 32'h0, '0, '0, d);
        check("R3 mask kept with line low", d, 32'hC);
        op(K_WR, A_K, 32'h0, '0, '0, d);
        op(K_RD, A_K, 32'h0, '0, '0, d);
        check("R11 control readback", d, 32'h0);
        op(K_RD, A_A, 32'h0, '0, '0, d);
        check("R11 auto-mask readback", d, 32'h3);

        // R10 pulse during clearing read
        clean();
        op(K_NOP, A_C, 32'h0, 31'h1, '0, d);
        op(K_RD, A_C, 32'h0, 31'h2, '0, d);
        check("R10 read value", d, 32'h8000_0001);
        check("R10 irq stays", {31'h0, irq_o}, 32'h1);
        op(K_RD, A_C, 32'h0, '0, '0, d);
        check("R10 cause survived", d, 32'h8000_0002);

        // R7 throttle, later cause does not restart (R5)
        clean();
        op(K_WR, A_I, 32'h1, '0, '0, d);
        op(K_NOP, A_C, 32'h0, 31'h1, '0, d);
        check("R7 irq at start", {31'h0, irq_o}, 32'h0);
        repeat (49) @(posedge clk);
        op(K_NOP, A_C, 32'h0, 31'h2, '0, d);
        repeat (77) @(posedge clk);
        #1 check("R7 irq one edge early", {31'h0, irq_o}, 32'h0);
        @(posedge clk);
        #1 check("R7 R5 irq at 128 edges", {31'h0, irq_o}, 32'h1);

        // R9 cancel and fresh restart
        clean();
        op(K_WR, A_I, 32'h1, '0, '0, d);
        op(K_NOP, A_C, 32'h0, 31'h1, '0, d);
        repeat (59) @(posedge clk);
        op(K_WR, A_M, 32'h0, '0, '0, d);
        op(K_WR, A_M, 32'hF, '0, '0, d);
        repeat (127) @(posedge clk);
        #1 check("R9 no stale expiry", {31'h0, irq_o}, 32'h0);
        @(posedge clk);
        #1 check("R9 restarted count expires", {31'h0, irq_o}, 32'h1);

        // R8 urgent bypass
        clean();
        op(K_WR, A_I, 32'h1, '0, '0, d);
        op(K_NOP, A_C, 32'h0, 31'h1, '0, d);
        op(K_NOP, A_C, 32'h0, '0, 31'h2, d);
        check("R8 urgent raises at once", {31'h0, irq_o}, 32'h1);

        // R5 urgent of a pending cause
        clean();
        op(K_WR, A_I, 32'h1, '0, '0, d);
        op(K_NOP, A_C, 32'h0, 31'h1, '0, d);
        op(K_NOP, A_C, 32'h0, '0, 31'h1, d);
        check("R5 repost urgent ignored", {31'h0, irq_o}, 32'h0);
        repeat (126) @(posedge clk);
        #1 check("R5 count not disturbed early", {31'h0, irq_o}, 32'h0);
        @(posedge clk);
        #1 check("R5 count not disturbed", {31'h0, irq_o}, 32'h1);

        // R7 interval of two units, R11 readback
        clean();
        op(K_WR, A_I, 32'h2, '0, '0, d);
        op(K_RD, A_I, 32'h0, '0, '0, d);
        check("R11 interval readback", d, 32'h2);
        op(K_NOP, A_C, 32'h0, 31'h4, '0, d);
        repeat (255) @(posedge clk);
        #1 check("R7 two units early", {31'h0, irq_o}, 32'h0);
        @(posedge clk);
        #1 check("R7 two units expire", {31'h0, irq_o}, 32'h1);

        finish_run();
    end
endmodule